// File: doc/BRIEF.md
# Two-Word Host Message FIFO

This block carries short messages between a host processor and a processing engine. Traffic from the host to the engine goes through an inbound FIFO. Traffic from the engine to the host goes through an outbound FIFO. The host reaches both FIFOs through one data address: a write to it pushes a word into the inbound FIFO, and a read from it pops a word from the outbound FIFO. A message is two 32-bit words, and each FIFO holds exactly one message. Before sending, the host checks that the inbound FIFO is empty. Before writing the second word, it checks that the FIFO is not full.

The host also sees three more registers:
- A status register. It holds four fill flags, four event flags and four sticky error bits.
- A control register. It holds FIFO enables, per-direction write enables and interrupt enables.
- A mailbox register. A host write of any value restores it to 0x0000F0F0.

The engine side is a plain pop/push port, with a mailbox load and a watch event input. A single interrupt line is raised when an enabled event flag is set.

Top module: `hostmsg_fifo`

## Requirements
- R1: After reset, the status register (address 1) reads 0x00060000, the control register (address 2) reads 0, the mailbox (address 3) reads 0x0000F0F0, and `irq` is low.
- R2: With control bits 17 and 25 set, a host write to address 0 pushes the inbound FIFO. The engine sees the words in order on `eng_in_data`, with `eng_in_valid` high. Status bit 19 (inbound not empty) and bit 17 (inbound not full) track the fill level.
- R3: With control bit 16 set, a host read of address 0 returns the oldest outbound word in the same cycle and pops it. Status bit 16 (outbound not empty) and bit 18 (outbound not full) track the fill level, and `eng_out_ready` equals bit 18.
- R4: Each FIFO holds two words. A push into a full FIFO is dropped and leaves the contents unchanged. It sets sticky bit 0 for the inbound FIFO and bit 2 for the outbound FIFO.
- R5: A pop from an empty FIFO is dropped. An empty host read of address 0 returns 0. An empty pop sets sticky bit 1 for an engine pop of the inbound FIFO and bit 3 for a host read of the outbound FIFO.
- R6: A push and a pop in the same cycle on a full FIFO both succeed. On an empty FIFO, the push is accepted and the pop counts as an underflow.
- R7: When control bit 25 (inbound) or bit 24 (outbound) is clear, pushes into that FIFO are ignored and set no error bit.
- R8: When control bit 17 (inbound) or bit 16 (outbound) is clear, that FIFO is emptied from the next cycle on. While it is disabled, pushes and pops on it are ignored.
- R9: Event flags are set as follows:
  - bit 20 on an engine mailbox load;
  - bit 21 when an engine pop empties the inbound FIFO;
  - bit 22 on every accepted engine push;
  - bit 23 on a watch event.
- R10: A host write to address 1 clears each event flag and sticky bit whose data bit is one. A set and a clear in the same cycle leave the bit set.
- R11: `irq` is high exactly when an event flag in status bits 23:20 is set and the control bit in the same position is set.
- R12: A host write of any value to address 3 sets the mailbox to 0x0000F0F0. An engine mailbox load writes its data. The host write wins when both happen in the same cycle.
- R13: `host_rdata` always shows the addressed register. Reading addresses 1 to 3 has no side effect. The writable control bits are 16, 17, 20 to 25, and the other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 mailbox |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops outbound at address 0) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Addressed register value, combinational |
| eng_in_pop | input | 1 | Engine pops the inbound FIFO |
| eng_in_valid | output | 1 | Inbound FIFO holds a word |
| eng_in_data | output | 32 | Oldest inbound word, 0 when empty |
| eng_out_push | input | 1 | Engine pushes the outbound FIFO |
| eng_out_data | input | 32 | Word pushed by the engine |
| eng_out_ready | output | 1 | Outbound FIFO has room |
| eng_mbox_wr | input | 1 | Engine loads the mailbox |
| eng_mbox_data | input | 32 | Mailbox load value |
| eng_watch_evt | input | 1 | Watch event pulse |
| irq | output | 1 | Masked OR of the event flags |

## Verification
The embedded properties check the following on every cycle:
- the FIFO occupancy bound and the hold on a full FIFO;
- that flushing empties a FIFO;
- the set-wins and write-one-clear behaviour of both flag banks;
- the mailbox restore value;
- the zero returned by an empty data read;
- the rise of `irq` after an enabled outbound push.

Word order through each FIFO, a push and a pop in the same cycle, write enables that drop data silently, and interrupt masking only show up across multi-cycle sequences. The bench's reference model and its scenarios cover those.

// File: rtl/hmq_pkg.sv
package hmq_pkg;

  localparam int HMQ_W = 32;

  typedef enum logic [1:0] {
    HMQ_A_DATA = 2'd0,
    HMQ_A_STAT = 2'd1,
    HMQ_A_CTRL = 2'd2,
    HMQ_A_MBOX = 2'd3
  } hmq_addr_e;

  // status layout
  localparam int ST_OUT_NE = 16;
  localparam int ST_IN_NF  = 17;
  localparam int ST_OUT_NF = 18;
  localparam int ST_IN_NE  = 19;
  localparam int ST_EVT_LO = 20;

  // control layout
  localparam int CT_OUT_EN = 16;
  localparam int CT_IN_EN  = 17;
  localparam int CT_IEN_LO = 20;
  localparam int CT_OUT_WE = 24;
  localparam int CT_IN_WE  = 25;
  localparam logic [HMQ_W-1:0] CT_MASK = 32'h03F3_0000;

  localparam logic [HMQ_W-1:0] MBOX_RST = 32'h0000_F0F0;

  // event flag indices
  localparam int EV_MBOX  = 0;
  localparam int EV_IN    = 1;
  localparam int EV_OUT   = 2;
  localparam int EV_WATCH = 3;

  // sticky error indices
  localparam int ER_IN_OVF  = 0;
  localparam int ER_IN_UDF  = 1;
  localparam int ER_OUT_OVF = 2;
  localparam int ER_OUT_UDF = 3;

  function automatic logic hmq_flag_next(input logic cur, input logic set,
                                         input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [HMQ_W-1:0] hmq_status_word(
      input logic [3:0] evt, input logic in_ne, input logic out_nf,
      input logic in_nf, input logic out_ne, input logic [3:0] err);
    logic [HMQ_W-1:0] w;
    w = '0;
    w[3:0] = err;
    w[ST_OUT_NE] = out_ne;
    w[ST_IN_NF] = in_nf;
    w[ST_OUT_NF] = out_nf;
    w[ST_IN_NE] = in_ne;
    w[ST_EVT_LO +: 4] = evt;
    return w;
  endfunction

  function automatic logic hmq_masked_any(input logic [3:0] flags,
                                          input logic [3:0] en);
    return |(flags & en);
  endfunction

endpackage

// File: rtl/hmq_fifo.sv
module hmq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf_evt,
  output logic             udf_evt,
  output logic             drained
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_adv(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop & ~flush & ~empty;
  assign push_ok = push & ~flush & (~full | pop_ok);
  assign ovf_evt = push & ~flush & ~push_ok;
  assign udf_evt = pop & ~flush & ~pop_ok;
  assign drained = pop_ok & ~push_ok & (cnt_q == CNT_W'(1));
  assign rdata   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_adv(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_adv(rd_ptr);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R4
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> full && $stable(rd_ptr)); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R8

endmodule

// File: rtl/hmq_flagbank.sv
module hmq_flagbank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  import hmq_pkg::*;

  logic [N-1:0] flag_q, flag_nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign flag_nxt[i] = hmq_flag_next(flag_q[i], set[i], clr_stb & clr_mask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_nxt;
  end

  assign flags = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags & $past(set)) == $past(set))); // R10
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((flags & $past(clr_mask & ~set)) == '0)); // R10

endmodule

// File: rtl/hostmsg_fifo.sv
module hostmsg_fifo #(
  parameter int FIFO_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        eng_in_pop,
  output logic        eng_in_valid,
  output logic [31:0] eng_in_data,
  input  logic        eng_out_push,
  input  logic [31:0] eng_out_data,
  output logic        eng_out_ready,
  input  logic        eng_mbox_wr,
  input  logic [31:0] eng_mbox_data,
  input  logic        eng_watch_evt,
  output logic        irq
);
  import hmq_pkg::*;

  localparam int NFLAG = 4;

  hmq_addr_e addr;
  logic hit_data_wr, hit_stat_wr, hit_ctrl_wr, hit_mbox_wr, hit_data_rd;
  logic [HMQ_W-1:0] ctrl_q, mbox_q, status;

  // inbound FIFO wires
  logic in_flush, in_push, in_empty, in_full, in_push_ok, in_pop_ok;
  logic in_ovf, in_udf, in_drained;
  // outbound FIFO wires
  logic out_flush, out_push, out_empty, out_full, out_push_ok, out_pop_ok;
  logic out_ovf, out_udf, out_drained;
  logic [HMQ_W-1:0] out_head;

  logic [NFLAG-1:0] evt_set, evt_flags, err_set, err_flags;

  assign addr        = hmq_addr_e'(host_addr);
  assign hit_data_wr = host_wr && (addr == HMQ_A_DATA);
  assign hit_stat_wr = host_wr && (addr == HMQ_A_STAT);
  assign hit_ctrl_wr = host_wr && (addr == HMQ_A_CTRL);
  assign hit_mbox_wr = host_wr && (addr == HMQ_A_MBOX);
  assign hit_data_rd = host_rd && (addr == HMQ_A_DATA);

  assign in_flush  = ~ctrl_q[CT_IN_EN];
  assign in_push   = hit_data_wr & ctrl_q[CT_IN_WE];
  assign out_flush = ~ctrl_q[CT_OUT_EN];
  assign out_push  = eng_out_push & ctrl_q[CT_OUT_WE];

  hmq_fifo #(.WIDTH(HMQ_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .flush(in_flush),
    .push(in_push), .pop(eng_in_pop), .wdata(host_wdata),
    .rdata(eng_in_data), .empty(in_empty), .full(in_full),
    .push_ok(in_push_ok), .pop_ok(in_pop_ok),
    .ovf_evt(in_ovf), .udf_evt(in_udf), .drained(in_drained)
  );

  hmq_fifo #(.WIDTH(HMQ_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .flush(out_flush),
    .push(out_push), .pop(hit_data_rd), .wdata(eng_out_data),
    .rdata(out_head), .empty(out_empty), .full(out_full),
    .push_ok(out_push_ok), .pop_ok(out_pop_ok),
    .ovf_evt(out_ovf), .udf_evt(out_udf), .drained(out_drained)
  );

  always_comb begin
    evt_set = '0;
    evt_set[EV_MBOX]  = eng_mbox_wr;
    evt_set[EV_IN]    = in_drained;
    evt_set[EV_OUT]   = out_push_ok;
    evt_set[EV_WATCH] = eng_watch_evt;
    err_set = '0;
    err_set[ER_IN_OVF]  = in_ovf;
    err_set[ER_IN_UDF]  = in_udf;
    err_set[ER_OUT_OVF] = out_ovf;
    err_set[ER_OUT_UDF] = out_udf;
  end

  hmq_flagbank #(.N(NFLAG)) u_evt_flags (
    .clk(clk), .rst_n(rst_n), .set(evt_set), .clr_stb(hit_stat_wr),
    .clr_mask(host_wdata[ST_EVT_LO +: NFLAG]), .flags(evt_flags)
  );

  hmq_flagbank #(.N(NFLAG)) u_err_flags (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr_stb(hit_stat_wr),
    .clr_mask(host_wdata[NFLAG-1:0]), .flags(err_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mbox_q <= MBOX_RST;
    end else begin
      if (hit_ctrl_wr) ctrl_q <= host_wdata & CT_MASK;
      if (hit_mbox_wr)      mbox_q <= MBOX_RST;
      else if (eng_mbox_wr) mbox_q <= eng_mbox_data;
    end
  end

  assign status = hmq_status_word(evt_flags, ~in_empty, ~out_full, ~in_full,
                                  ~out_empty, err_flags);

  always_comb begin
    unique case (addr)
      HMQ_A_DATA: host_rdata = out_head;
      HMQ_A_STAT: host_rdata = status;
      HMQ_A_CTRL: host_rdata = ctrl_q;
      default:    host_rdata = mbox_q;
    endcase
  end

  assign eng_in_valid  = ~in_empty;
  assign eng_out_ready = ~out_full;
  assign irq = hmq_masked_any(evt_flags, ctrl_q[CT_IEN_LO +: NFLAG]);

  AST_MBOX_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mbox_wr |=> mbox_q == MBOX_RST); // R12
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_data_rd && out_empty |-> host_rdata == '0); // R5
  AST_OUT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_push_ok && ctrl_q[CT_IEN_LO + EV_OUT] && !hit_ctrl_wr |=> irq); // R11
  AST_IN_ORDER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop_ok && !in_push_ok && !in_flush && !in_drained |=> !in_empty); // R2
  AST_OUT_POP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    out_pop_ok && !out_push_ok && !out_drained |=> !out_empty); // R3

endmodule

// File: tb/hostmsg_fifo_bench.sv
module hostmsg_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        eng_in_pop = 1'b0;
  logic        eng_in_valid;
  logic [31:0] eng_in_data;
  logic        eng_out_push = 1'b0;
  logic [31:0] eng_out_data = '0;
  logic        eng_out_ready;
  logic        eng_mbox_wr = 1'b0;
  logic [31:0] eng_mbox_data = '0;
  logic        eng_watch_evt = 1'b0;
  logic        irq;

  always #2 clk = ~clk;

  hostmsg_fifo u_hostmsg_fifo (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_in_pop(eng_in_pop), .eng_in_valid(eng_in_valid),
    .eng_in_data(eng_in_data), .eng_out_push(eng_out_push),
    .eng_out_data(eng_out_data), .eng_out_ready(eng_out_ready),
    .eng_mbox_wr(eng_mbox_wr), .eng_mbox_data(eng_mbox_data),
    .eng_watch_evt(eng_watch_evt), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  logic [31:0] m_in[$], m_out[$];
  logic [3:0]  m_err = '0, m_evt = '0;
  logic [31:0] m_ctrl = '0, m_mbox = 32'h0000F0F0;

  logic [31:0] last_rdata, last_in_data;
  logic        last_irq, last_in_valid, last_out_ready;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] w = '0;
    w[3:0] = m_err;
    w[16] = m_out.size() != 0;
    w[17] = m_in.size() < 2;
    w[18] = m_out.size() < 2;
    w[19] = m_in.size() != 0;
    w[23:20] = m_evt;
    return w;
  endfunction

  function automatic logic [31:0] m_rdata();
    case (host_addr)
      2'd0: return (m_out.size() != 0) ? m_out[0] : 32'h0;
      2'd1: return m_status();
      2'd2: return m_ctrl;
      default: return m_mbox;
    endcase
  endfunction

  task automatic m_update();
    logic [3:0] es = '0, ev = '0;
    bit push, pop, pok;
    logic [31:0] wd = host_wdata;
    // inbound
    if (m_ctrl[17]) begin
      push = host_wr && host_addr == 2'd0 && m_ctrl[25];
      pop = eng_in_pop;
      pok = pop && m_in.size() != 0;
      if (pok) void'(m_in.pop_front());
      if (pop && !pok) es[1] = 1'b1;
      if (push) begin
        if (m_in.size() < 2) m_in.push_back(wd);
        else es[0] = 1'b1;
      end
      if (pok && !(push && !es[0]) && m_in.size() == 0) ev[1] = 1'b1;
    end else m_in.delete();
    // outbound
    if (m_ctrl[16]) begin
      push = eng_out_push && m_ctrl[24];
      pop = host_rd && host_addr == 2'd0;
      pok = pop && m_out.size() != 0;
      if (pok) void'(m_out.pop_front());
      if (pop && !pok) es[3] = 1'b1;
      if (push) begin
        if (m_out.size() < 2) begin m_out.push_back(eng_out_data); ev[2] = 1'b1; end
        else es[2] = 1'b1;
      end
    end else m_out.delete();
    ev[0] = eng_mbox_wr;
    ev[3] = eng_watch_evt;
    if (host_wr && host_addr == 2'd1) begin
      m_err = m_err & ~wd[3:0];
      m_evt = m_evt & ~wd[23:20];
    end
    m_err = m_err | es;
    m_evt = m_evt | ev;
    if (host_wr && host_addr == 2'd2) m_ctrl = wd & 32'h03F30000;
    if (host_wr && host_addr == 2'd3) m_mbox = 32'h0000F0F0;
    else if (eng_mbox_wr) m_mbox = eng_mbox_data;
  endtask

  // one cycle: inputs already set at negedge
  task automatic tick();
    #1;
    last_rdata = host_rdata;
    last_irq = irq;
    last_in_valid = eng_in_valid;
    last_in_data = eng_in_data;
    last_out_ready = eng_out_ready;
    chk("R13 rdata", host_rdata, m_rdata());
    chk("R11 irq", {31'b0, irq}, {31'b0, |(m_evt & m_ctrl[23:20])});
    chk("R2 in_valid", {31'b0, eng_in_valid}, {31'b0, m_in.size() != 0});
    chk("R2 in_data", eng_in_data, (m_in.size() != 0) ? m_in[0] : 32'h0);
    chk("R3 out_ready", {31'b0, eng_out_ready}, {31'b0, m_out.size() < 2});
    @(posedge clk);
    m_update();
    @(negedge clk);
    host_wr = 0; host_rd = 0; eng_in_pop = 0; eng_out_push = 0;
    eng_mbox_wr = 0; eng_watch_evt = 0;
  endtask

  task automatic hwrite(logic [1:0] a, logic [31:0] d);
    host_addr = a; host_wr = 1; host_wdata = d; tick();
  endtask
  task automatic hread(logic [1:0] a);
    host_addr = a; host_rd = 1; tick();
  endtask
  task automatic epush(logic [31:0] d);
    eng_out_push = 1; eng_out_data = d; tick();
  endtask
  task automatic epop();
    eng_in_pop = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    hread(2'd1); chk("R1 status", last_rdata, 32'h00060000);
    chk("R1 irq", {31'b0, last_irq}, 32'h0);
    hread(2'd2); chk("R1 ctrl", last_rdata, 32'h0);
    hread(2'd3); chk("R12 mbox reset", last_rdata, 32'h0000F0F0);
    hwrite(2'd2, 32'hFFFF_FFFF);
    hread(2'd2); chk("R13 ctrl mask", last_rdata, 32'h03F30000);

    // R2 / R4 inbound fill and overflow
    hwrite(2'd0, 32'h11111111);
    hwrite(2'd0, 32'h22222222);
    hread(2'd1); chk("R2 in full flags", last_rdata & 32'h000A0000, 32'h00080000);
    hwrite(2'd0, 32'h33333333);
    hread(2'd1); chk("R4 in ovf", last_rdata & 32'h1, 32'h1);
    epop(); chk("R2 first word", last_in_data, 32'h11111111);
    epop(); chk("R2 second word", last_in_data, 32'h22222222);
    hread(2'd1); chk("R9 in drained flag", last_rdata & 32'h00200000, 32'h00200000);
    chk("R11 irq on drain", {31'b0, last_irq}, 32'h1);
    epop();
    hread(2'd1); chk("R5 in udf", last_rdata & 32'h2, 32'h2);
    hwrite(2'd1, 32'hFFFF_FFFF);
    hread(2'd1); chk("R10 w1c", last_rdata & 32'h00F0000F, 32'h0);
    chk("R10 irq cleared", {31'b0, last_irq}, 32'h0);

    // R3 / R4 / R5 outbound
    epush(32'hAAAA0001);
    epush(32'hAAAA0002);
    epush(32'hAAAA0003);
    hread(2'd1); chk("R3 out flags", last_rdata & 32'h00050000, 32'h00010000);
    chk("R4 out ovf", last_rdata & 32'h4, 32'h4);
    chk("R9 out flag", last_rdata & 32'h00400000, 32'h00400000);
    hread(2'd0); chk("R3 out first", last_rdata, 32'hAAAA0001);
    hread(2'd0); chk("R3 out second", last_rdata, 32'hAAAA0002);
    hread(2'd0); chk("R5 empty read", last_rdata, 32'h0);
    hread(2'd1); chk("R5 out udf", last_rdata & 32'h8, 32'h8);
    hwrite(2'd1, 32'hFFFF_FFFF);

    // R6 simultaneous push and pop
    epush(32'hC0000001);
    epush(32'hC0000002);
    host_addr = 2'd0; host_rd = 1; eng_out_push = 1; eng_out_data = 32'hC0000003; tick();
    chk("R6 full rd", last_rdata, 32'hC0000001);
    hread(2'd0); chk("R6 next", last_rdata, 32'hC0000002);
    hread(2'd0); chk("R6 pushed", last_rdata, 32'hC0000003);
    hread(2'd1); chk("R6 no ovf", last_rdata & 32'h4, 32'h0);
    host_addr = 2'd0; host_wr = 1; host_wdata = 32'hD0000001; eng_in_pop = 1; tick();
    hread(2'd1); chk("R6 empty pop udf", last_rdata & 32'h00080002, 32'h00080002);
    epop(); chk("R6 accepted word", last_in_data, 32'hD0000001);
    hwrite(2'd1, 32'hFFFF_FFFF);

    // R7 write enables off
    hwrite(2'd2, 32'h00F30000);
    hwrite(2'd0, 32'hE0000001);
    hread(2'd1); chk("R7 in ignored", last_rdata & 32'h00080001, 32'h0);
    epush(32'hE0000002);
    hread(2'd1); chk("R7 out ignored", last_rdata & 32'h00410004, 32'h0);

    // R8 FIFO enable off flushes
    hwrite(2'd2, 32'h03F30000);
    hwrite(2'd0, 32'hF0000001);
    tick(); chk("R8 loaded", {31'b0, last_in_valid}, 32'h1);
    hwrite(2'd2, 32'h03F10000);
    tick();
    tick(); chk("R8 flushed", {31'b0, last_in_valid}, 32'h0);
    hwrite(2'd0, 32'hF0000002);
    hwrite(2'd2, 32'h03F30000);
    tick(); chk("R8 ignored while off", {31'b0, last_in_valid}, 32'h0);

    // R12 mailbox, R9 / R10 / R11 masking
    hwrite(2'd1, 32'hFFFF_FFFF);
    eng_mbox_wr = 1; eng_mbox_data = 32'h12345678; tick();
    hread(2'd3); chk("R12 engine load", last_rdata, 32'h12345678);
    hread(2'd1); chk("R9 mbox flag", last_rdata & 32'h00100000, 32'h00100000);
    hwrite(2'd3, 32'h0);
    hread(2'd3); chk("R12 host restore", last_rdata, 32'h0000F0F0);
    host_addr = 2'd3; host_wr = 1; eng_mbox_wr = 1; eng_mbox_data = 32'hDEAD; tick();
    hread(2'd3); chk("R12 host wins", last_rdata, 32'h0000F0F0);
    hwrite(2'd1, 32'hFFFF_FFFF);
    hwrite(2'd2, 32'h03830000);
    eng_mbox_wr = 1; eng_mbox_data = 32'h1; tick();
    hread(2'd1); chk("R11 masked", {31'b0, last_irq}, 32'h0);
    eng_watch_evt = 1; tick();
    hread(2'd1); chk("R9 watch flag", last_rdata & 32'h00800000, 32'h00800000);
    chk("R11 enabled", {31'b0, last_irq}, 32'h1);
    host_addr = 2'd1; host_wr = 1; host_wdata = 32'h00800000; eng_watch_evt = 1; tick();
    hread(2'd1); chk("R10 set wins", last_rdata & 32'h00800000, 32'h00800000);
    hwrite(2'd1, 32'h00800000);
    hread(2'd1); chk("R10 cleared", {31'b0, last_irq}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule